// File: doc/BRIEF.md
# Two-Input Two-Output Packet Switch Arbiter

This block joins two packet inputs to two packet outputs. Each input feeds its own first-in first-out buffer, which holds `CAP` entries. Every cycle the block looks at the oldest packet in each buffer. It decides whether both packets move to their outputs together, only one moves, or none moves.

A packet is one flat word laid out as `{payload, interesting, dest}`:
- Bit 0 (`dest`) picks the output: 0 selects output 0 and 1 selects output 1.
- Bit 1 is the interesting flag.
- The bits above bit 1 are the payload, which the block does not inspect.

Both sides of the block use valid/ready handshakes. An offer that an output has not yet taken stays on that output, unchanged, until the output's ready is high.

The parameter `MODE` selects which input wins when both head packets are interesting and are bound for different outputs. `MODE` = 0 favours input 0. `MODE` = 1 favours input 1.

Top module: `pkt_xbar2`

## Requirements
- R1: `inN_ready` is high exactly while buffer N holds fewer than `CAP` packets. A packet is stored when `inN_valid` and `inN_ready` are both high at a clock edge.
- R2: Each buffer releases its packets in arrival order, and only the oldest packet is ever offered.
- R3: With no output stalled and both buffers non-empty, both head packets are offered in the same cycle only when their dest bits differ and at most one of them has bit 1 set.
- R4: With no output stalled and both head packets carrying the same dest, only the packet from input 0 is offered. Input 1 waits.
- R5: With `MODE` = 0, no output stalled, both head packets having bit 1 set and different dest bits, only input 0 is offered.
- R6: With `MODE` = 1, in the same situation as R5, only input 1 is offered and input 0 waits.
- R7: A packet is only ever offered on the output given by its bit 0. When only one buffer holds packets, its head is offered at once.
- R8: A packet leaves its buffer only at an edge where it is offered and its output's ready is high. An offer made while that ready is low repeats, with the same data, in the next cycle, and no later arrival displaces it. The other output is then arbitrated against it under the rules of R3.
- R9: A synchronous active-high `rst` empties both buffers, clears any held offer, drives both output valids low and drives both input readies high.
- R10: A buffer that is pushed and popped in the same cycle keeps its occupancy, and its ready flag stays correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | Input 0 offers a packet |
| in0_ready | output | 1 | Buffer 0 has room |
| in0_data | input | PW+2 | Input 0 packet |
| in1_valid | input | 1 | Input 1 offers a packet |
| in1_ready | output | 1 | Buffer 1 has room |
| in1_data | input | PW+2 | Input 1 packet |
| out0_valid | output | 1 | Output 0 carries a packet |
| out0_ready | input | 1 | Output 0 takes the packet |
| out0_data | output | PW+2 | Output 0 packet |
| out1_valid | output | 1 | Output 1 carries a packet |
| out1_ready | input | 1 | Output 1 takes the packet |
| out1_data | output | PW+2 | Output 1 packet |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the buffers and the held-offer state start out defined. They also assume that `outN_data` is only meaningful while `outN_valid` is high.

The stimulus meets these assumptions as follows:
- It starts the run in reset and changes inputs only at the falling clock edge.
- It draws every packet, valid and ready from a seeded `$urandom`. The dest and interesting bits are drawn with weights, so that same-destination, both-interesting and stalled-output cases occur often.
- It adds directed phases that fill both buffers and that apply reset with packets still held.

// File: rtl/pkt_xbar2.sv
module pkt_xbar2 #(
  parameter int CAP  = 4,
  parameter int PW   = 8,
  parameter bit MODE = 1'b0,
  localparam int PKW = PW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in0_valid,
  output logic           in0_ready,
  input  logic [PKW-1:0] in0_data,
  input  logic           in1_valid,
  output logic           in1_ready,
  input  logic [PKW-1:0] in1_data,
  output logic           out0_valid,
  input  logic           out0_ready,
  output logic [PKW-1:0] out0_data,
  output logic           out1_valid,
  input  logic           out1_ready,
  output logic [PKW-1:0] out1_data
);
  localparam int AW = (CAP > 1) ? $clog2(CAP) : 1;
  localparam int CW = $clog2(CAP + 1);

  logic [1:0]     iv, ir, hv, g, pop, ov, ordy, lk, ls, src, fx;
  logic [PKW-1:0] id [2];
  logic [PKW-1:0] head [2];
  logic [PKW-1:0] od [2];
  logic           same, bint;

  assign iv    = {in1_valid, in0_valid};
  assign id[0] = in0_data;
  assign id[1] = in1_data;
  assign ordy  = {out1_ready, out0_ready};
  assign in0_ready = ir[0];
  assign in1_ready = ir[1];

  for (genvar b = 0; b < 2; b++) begin : buf_g
    logic [PKW-1:0] mem [CAP];
    logic [AW-1:0]  rp, wp;
    logic [CW-1:0]  cnt;
    logic           push;

    assign ir[b]   = cnt < CW'(CAP);
    assign hv[b]   = cnt != '0;
    assign push    = iv[b] & ir[b];
    assign head[b] = mem[rp];

    always_ff @(posedge clk) begin
      if (rst) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (push) begin
          mem[wp] <= id[b];
          wp <= (wp == AW'(CAP - 1)) ? '0 : wp + 1'b1;
        end
        if (pop[b]) rp <= (rp == AW'(CAP - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop[b]);
      end
    end
  end

  assign same  = head[0][0] == head[1][0];
  assign bint  = head[0][1] & head[1][1];
  assign fx[0] = (lk[0] & ~ls[0]) | (lk[1] & ~ls[1]);
  assign fx[1] = (lk[0] &  ls[0]) | (lk[1] &  ls[1]);

  always_comb begin
    if (|fx) begin
      g[0] = fx[0] | (hv[0] & ~same & ~bint);
      g[1] = fx[1] | (hv[1] & ~same & ~bint);
    end else begin
      g[0] = hv[0] & (~hv[1] | same | ~bint | ~MODE);
      g[1] = hv[1] & (~hv[0] | (~same & (~bint | MODE)));
    end
  end

  for (genvar k = 0; k < 2; k++) begin : out_g
    logic from0, from1;
    assign from0  = g[0] & (head[0][0] == 1'(k));
    assign from1  = g[1] & (head[1][0] == 1'(k));
    assign ov[k]  = from0 | from1;
    assign src[k] = ~from0;
    assign od[k]  = from0 ? head[0] : head[1];
  end

  assign pop[0] = g[0] & ordy[head[0][0]];
  assign pop[1] = g[1] & ordy[head[1][0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk <= '0;
      ls <= '0;
    end else begin
      lk <= ov & ~ordy;
      ls <= src;
    end
  end

  assign out0_valid = ov[0];
  assign out0_data  = od[0];
  assign out1_valid = ov[1];
  assign out1_data  = od[1];
endmodule

module pkt_xbar2_chk #(parameter int PKW = 10) (
  input logic           clk,
  input logic           rst,
  input logic           o0v,
  input logic           o0r,
  input logic [PKW-1:0] o0d,
  input logic           o1v,
  input logic           o1r,
  input logic [PKW-1:0] o1d,
  input logic           i0r,
  input logic           i1r
);
  // R3
  pair_int_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (o0v && o1v) |-> !(o0d[1] && o1d[1]));
  // R7
  route0_chk: assert property (@(posedge clk) disable iff (rst) o0v |-> (o0d[0] == 1'b0));
  // R7
  route1_chk: assert property (@(posedge clk) disable iff (rst) o1v |-> (o1d[0] == 1'b1));
  // R8
  hold0_chk: assert property (@(posedge clk) disable iff (rst)
    (o0v && !o0r) |=> (o0v && $stable(o0d)));
  // R8
  hold1_chk: assert property (@(posedge clk) disable iff (rst)
    (o1v && !o1r) |=> (o1v && $stable(o1d)));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!o0v && !o1v && i0r && i1r));
endmodule

bind pkt_xbar2 pkt_xbar2_chk #(.PKW(PKW)) u_chk (
  .clk(clk), .rst(rst),
  .o0v(out0_valid), .o0r(out0_ready), .o0d(out0_data),
  .o1v(out1_valid), .o1r(out1_ready), .o1d(out1_data),
  .i0r(in0_ready), .i1r(in1_ready)
);

// File: tb/sim_pkt_xbar2.sv
`timescale 1ns/1ps
module sim_pkt_xbar2;
  localparam int CAP = 3;
  localparam int PW  = 8;
  localparam int PKW = PW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           iv [2];
  logic [PKW-1:0] idt [2];
  logic           ordy [2];
  logic           ov [2][2];
  logic [PKW-1:0] od [2][2];
  logic           ir [2][2];

  pkt_xbar2 #(.CAP(CAP), .PW(PW), .MODE(1'b0)) u0 (
    .clk(clk), .rst(rst),
    .in0_valid(iv[0]), .in0_ready(ir[0][0]), .in0_data(idt[0]),
    .in1_valid(iv[1]), .in1_ready(ir[0][1]), .in1_data(idt[1]),
    .out0_valid(ov[0][0]), .out0_ready(ordy[0]), .out0_data(od[0][0]),
    .out1_valid(ov[0][1]), .out1_ready(ordy[1]), .out1_data(od[0][1]));

  pkt_xbar2 #(.CAP(CAP), .PW(PW), .MODE(1'b1)) u1 (
    .clk(clk), .rst(rst),
    .in0_valid(iv[0]), .in0_ready(ir[1][0]), .in0_data(idt[0]),
    .in1_valid(iv[1]), .in1_ready(ir[1][1]), .in1_data(idt[1]),
    .out0_valid(ov[1][0]), .out0_ready(ordy[0]), .out0_data(od[1][0]),
    .out1_valid(ov[1][1]), .out1_ready(ordy[1]), .out1_data(od[1][1]));

  int checks = 0;
  int errors = 0;

  logic [PKW-1:0] mq [2][2][CAP];
  int             mc [2][2];
  bit             mlk [2][2];
  bit             mls [2][2];
  bit             bothpp [2][2];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] arb(input bit v0, v1, input logic [PKW-1:0] p0, p1,
                                     input bit f0, f1, input bit mode);
    bit same, bint;
    same = (p0[0] == p1[0]);
    bint = p0[1] && p1[1];
    if (f0 || f1)
      return {f1 | (v1 & !same & !bint), f0 | (v0 & !same & !bint)};
    if (v0 && v1) begin
      if (same) return 2'b01;
      if (bint) return mode ? 2'b10 : 2'b01;
      return 2'b11;
    end
    return {v1, v0};
  endfunction

  function automatic string tag_of(input bit v0, v1, input logic [PKW-1:0] p0, p1,
                                   input bit f0, f1, input bit mode);
    if (f0 || f1) return "R8";
    if (v0 && v1) begin
      if (p0[0] == p1[0]) return "R4";
      if (p0[1] && p1[1]) return mode ? "R6" : "R5";
      return "R3";
    end
    return "R7";
  endfunction

  task automatic clear_model();
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++) begin
        mc[d][p] = 0; mlk[d][p] = 0; mls[d][p] = 0; bothpp[d][p] = 0;
      end
  endtask

  task automatic step(input int pv, input int pr, input int pi, input int pd1);
    for (int p = 0; p < 2; p++) begin
      iv[p]  = ($urandom % 100) < pv;
      idt[p] = {PW'($urandom), 1'(($urandom % 100) < pi), 1'(($urandom % 100) < pd1)};
      ordy[p] = ($urandom % 100) < pr;
    end
    #1;
    for (int d = 0; d < 2; d++) begin
      bit v0, v1, f0, f1;
      logic [PKW-1:0] h0, h1;
      logic [1:0] g;
      string tg;
      bit ev [2];
      logic [PKW-1:0] ed [2];
      bit pu [2];
      bit po [2];
      v0 = mc[d][0] > 0;
      v1 = mc[d][1] > 0;
      h0 = mq[d][0][0];
      h1 = mq[d][1][0];
      f0 = (mlk[d][0] && !mls[d][0]) || (mlk[d][1] && !mls[d][1]);
      f1 = (mlk[d][0] && mls[d][0]) || (mlk[d][1] && mls[d][1]);
      g  = arb(v0, v1, h0, h1, f0, f1, bit'(d));
      tg = tag_of(v0, v1, h0, h1, f0, f1, bit'(d));
      for (int k = 0; k < 2; k++) begin
        bit a0, a1;
        a0 = g[0] && (h0[0] == 1'(k));
        a1 = g[1] && (h1[0] == 1'(k));
        ev[k] = a0 || a1;
        ed[k] = a0 ? h0 : h1;
        chk(tg, $sformatf("dut%0d out%0d_valid", d, k), 32'(ov[d][k]), 32'(ev[k]));
        if (ev[k]) chk("R2", $sformatf("dut%0d out%0d_data", d, k), 32'(od[d][k]), 32'(ed[k]));
      end
      for (int p = 0; p < 2; p++) begin
        bit exr;
        exr = mc[d][p] < CAP;
        chk(bothpp[d][p] ? "R10" : "R1", $sformatf("dut%0d in%0d_ready", d, p), 32'(ir[d][p]), 32'(exr));
        pu[p] = iv[p] && exr;
        po[p] = g[p] && ordy[(p == 0) ? h0[0] : h1[0]];
      end
      for (int p = 0; p < 2; p++) begin
        if (po[p]) begin
          for (int j = 0; j < CAP - 1; j++) mq[d][p][j] = mq[d][p][j + 1];
          mc[d][p]--;
        end
        if (pu[p]) begin
          mq[d][p][mc[d][p]] = idt[p];
          mc[d][p]++;
        end
        bothpp[d][p] = pu[p] && po[p];
      end
      for (int k = 0; k < 2; k++) begin
        mlk[d][k] = ev[k] && !ordy[k];
        mls[d][k] = !(g[0] && (h0[0] == 1'(k)));
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    iv[0] = 0; iv[1] = 0;
    @(posedge clk);
    @(negedge clk);
    #1;
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 2; k++) begin
        chk("R9", $sformatf("dut%0d out%0d_valid after reset", d, k), 32'(ov[d][k]), 32'd0);
        chk("R9", $sformatf("dut%0d in%0d_ready after reset", d, k), 32'(ir[d][k]), 32'd1);
      end
    clear_model();
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    iv[0] = 0; iv[1] = 0; idt[0] = '0; idt[1] = '0; ordy[0] = 0; ordy[1] = 0;
    clear_model();
    @(negedge clk);
    do_reset();
    // mixed traffic
    for (int n = 0; n < 2500; n++) step(70, 75, 50, 50);
    // R1: fill both buffers with outputs blocked, then drain
    for (int n = 0; n < 3 * CAP; n++) step(100, 0, 50, 50);
    for (int n = 0; n < 3 * CAP; n++) step(0, 100, 50, 50);
    // R5 R6: both heads interesting, destinations random
    for (int n = 0; n < 1000; n++) step(90, 80, 100, 50);
    // R4: all traffic to output 1
    for (int n = 0; n < 500; n++) step(90, 70, 50, 100);
    // R8: heavy output stalls
    for (int n = 0; n < 1000; n++) step(80, 20, 40, 50);
    // R9: reset with packets held
    for (int n = 0; n < 2 * CAP; n++) step(100, 0, 50, 50);
    do_reset();
    for (int n = 0; n < 500; n++) step(60, 60, 60, 40);
    finish_run();
  end
endmodule